// File: doc/BRIEF.md
# Operand Address Mode Generator

This block takes the addressing fields of one decoded instruction for a 16-bit processor and turns them into either an immediate operand or an effective memory address. It handles several modes: register, direct, indirect, immediate long, short positive and short negative immediates, counter-relative, base-relative and base-relative indexed. Decode pulses `start` for one cycle with the fields stable. The block reads two register file ports. Port A is addressed by the index field. Port B is addressed by the base register selected in R12-R15.

For every mode except indirect, the result appears one cycle after `start`, and `valid` is high for that one cycle. In indirect mode the block first forms a pointer. It raises a one-word memory read over a request/acknowledge port and holds the request until the acknowledge arrives. The fetched word becomes the effective address. All address sums wrap modulo 2^16, and no overflow is flagged.

Top module: `opnd_addr_gen`

## Requirements
- R1: After reset `valid` and `memReq` are low and `result` and `isAddr` are zero.
- R2: Mode code 0 (register): one cycle after `start`, `valid` is high, `result` equals the register named by `rxSel`, and `isAddr` is 0.
- R3: Mode code 1 (direct): `result` is `postWord` plus the contents of register `rxSel`, with the index term taken as zero when `rxSel` is 0. `isAddr` is 1, and the sum wraps modulo 2^16.
- R4: Mode code 2 (indirect): in the cycle after `start`, `memReq` is high, `valid` is low, and `memAddr` holds the indexed pointer (same rule as R3). `memReq` and `memAddr` hold until `memAck` is sampled high. One cycle after that, `valid` is high, `result` equals `memData` from the acknowledge cycle, `isAddr` is 1, and `memReq` is low.
- R5: Mode code 3 (immediate long): `result` is `postWord` plus the index term under the R3 rule, with `isAddr` 0.
- R6: Mode code 4 (short positive): with n = `dispField[3:0]`, `result` is n+1, which gives 0x0001 to 0x0010, with `isAddr` 0.
- R7: Mode code 5 (short negative): `result` is the two's-complement negation of n+1, which gives 0xFFFF down to 0xFFF0, with `isAddr` 0.
- R8: Mode code 6 (counter-relative): `result` is `instrCount` plus `dispField` sign-extended from 8 bits, with `isAddr` 1.
- R9: Mode code 7 (base-relative): `result` is register 12+`baseSel` plus `dispField` zero-extended, with `isAddr` 1.
- R10: Mode code 8 (base-relative indexed): `result` is register 12+`baseSel` plus the index term under the R3 rule, with `isAddr` 1.
- R11: A `start` while an indirect fetch is pending has no effect: it gives no extra `valid`, and the fetched result is delivered unchanged.
- R12: Mode codes 9 to 15 give `valid` one cycle after `start`, with `result` 0 and `isAddr` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request with fields stable |
| mode | input | 4 | Addressing mode code |
| rxSel | input | 4 | Index register field; 0 means no index |
| baseSel | input | 2 | Base register select (R12 + value) |
| dispField | input | 8 | Displacement, or short immediate in bits 3:0 |
| postWord | input | 16 | Instruction postword |
| instrCount | input | 16 | Instruction counter |
| rdAddrA | output | 4 | Register file port A address (index/register) |
| rdDataA | input | 16 | Register file port A data |
| rdAddrB | output | 4 | Register file port B address (base register) |
| rdDataB | input | 16 | Register file port B data |
| memReq | output | 1 | Indirect read request |
| memAddr | output | 16 | Indirect read pointer |
| memAck | input | 1 | Read acknowledge |
| memData | input | 16 | Read data, taken with memAck |
| valid | output | 1 | One-cycle result strobe |
| isAddr | output | 1 | 1: result is an address, 0: an operand |
| result | output | 16 | Operand or effective address |

## Verification
A wrong selection in the mode decode shows in the first `valid` cycle after `start`. The bench sweeps every index field, every base select, every short immediate and all 256 displacements, so the wrong value shows in `result` or `isAddr` there. A control state stuck in the fetch state shows at the ports as `memReq` staying high, or as `valid` missing or arriving one cycle off around the acknowledge. The bench checks both on the exact cycle, with acknowledge delays of zero to several cycles and with a `start` sent into the pending fetch.

// File: rtl/oag_pkg.sv
package oag_pkg;
  typedef enum logic [3:0] {
    MD_REG       = 4'd0,
    MD_DIRECT    = 4'd1,
    MD_INDIRECT  = 4'd2,
    MD_IMM_LONG  = 4'd3,
    MD_SHORT_POS = 4'd4,
    MD_SHORT_NEG = 4'd5,
    MD_REL_IC    = 4'd6,
    MD_BASE      = 4'd7,
    MD_BASE_IDX  = 4'd8
  } modeT;

  typedef struct packed {
    logic loadResult;
    logic loadPtr;
    logic loadFetched;
  } strobeT;
endpackage

// File: rtl/oag_ctrl.sv
module oag_ctrl
  import oag_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [3:0] mode,
  input  logic       memAck,
  output strobeT     strb,
  output logic       memReq,
  output logic       valid
);
  typedef enum logic {ST_IDLE, ST_FETCH} stateT;
  stateT state;
  logic  isInd;

  assign isInd = (mode == MD_INDIRECT);

  always_comb begin
    strb.loadResult  = (state == ST_IDLE) && start && !isInd;
    strb.loadPtr     = (state == ST_IDLE) && start && isInd;
    strb.loadFetched = (state == ST_FETCH) && memAck;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      valid <= 1'b0;
    end else begin
      valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start && isInd) state <= ST_FETCH;
          else if (start)     valid <= 1'b1;
        end
        ST_FETCH: begin
          if (memAck) begin
            state <= ST_IDLE;
            valid <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign memReq = (state == ST_FETCH);

  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && !valid));
  p_ack_valid_r4: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memAck) |=> (valid && !memReq));
  p_one_cycle_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!memReq && start && !isInd) |=> (valid && !memReq));
  p_ptr_issue_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!memReq && start && isInd) |=> (memReq && !valid));
endmodule

// File: rtl/oag_datapath.sv
module oag_datapath
  import oag_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int REG_IDX_W = 4,
  parameter int DISP_W    = 8,
  parameter int IMM_W     = 4
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  strobeT               strb,
  input  logic [3:0]           mode,
  input  logic [REG_IDX_W-1:0] rxSel,
  input  logic [DISP_W-1:0]    dispField,
  input  logic [WORD_W-1:0]    postWord,
  input  logic [WORD_W-1:0]    instrCount,
  input  logic [WORD_W-1:0]    rdDataA,
  input  logic [WORD_W-1:0]    rdDataB,
  input  logic                 memReq,
  input  logic                 memAck,
  input  logic [WORD_W-1:0]    memData,
  output logic [WORD_W-1:0]    memAddr,
  output logic [WORD_W-1:0]    result,
  output logic                 isAddr
);
  localparam int EXT_W = WORD_W - DISP_W;

  logic [WORD_W-1:0] indexTerm, dispZext, dispSext, immMag, postIdx, nextVal;
  logic              nextIsAddr;

  assign indexTerm = (rxSel != '0) ? rdDataA : '0;
  assign dispZext  = {{EXT_W{1'b0}}, dispField};
  assign dispSext  = {{EXT_W{dispField[DISP_W-1]}}, dispField};
  assign immMag    = {{(WORD_W-IMM_W){1'b0}}, dispField[IMM_W-1:0]} + WORD_W'(1);
  assign postIdx   = postWord + indexTerm;

  always_comb begin
    nextVal    = '0;
    nextIsAddr = 1'b0;
    case (mode)
      MD_REG:       nextVal = rdDataA;
      MD_DIRECT:    begin nextVal = postIdx; nextIsAddr = 1'b1; end
      MD_INDIRECT:  begin nextVal = postIdx; nextIsAddr = 1'b1; end
      MD_IMM_LONG:  nextVal = postIdx;
      MD_SHORT_POS: nextVal = immMag;
      MD_SHORT_NEG: nextVal = ~immMag + WORD_W'(1);
      MD_REL_IC:    begin nextVal = instrCount + dispSext; nextIsAddr = 1'b1; end
      MD_BASE:      begin nextVal = rdDataB + dispZext;    nextIsAddr = 1'b1; end
      MD_BASE_IDX:  begin nextVal = rdDataB + indexTerm;   nextIsAddr = 1'b1; end
      default:      begin nextVal = '0; nextIsAddr = 1'b0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result  <= '0;
      isAddr  <= 1'b0;
      memAddr <= '0;
    end else begin
      if (strb.loadResult) begin
        result <= nextVal;
        isAddr <= nextIsAddr;
      end
      if (strb.loadPtr) memAddr <= postIdx;
      if (strb.loadFetched) begin
        result <= memData;
        isAddr <= 1'b1;
      end
    end
  end

  p_ptr_stable_r4: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> $stable(memAddr));
  p_fetch_capture_r4: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memAck) |=> (result == $past(memData) && isAddr));
  p_pending_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> $stable(result));
endmodule

// File: rtl/opnd_addr_gen.sv
module opnd_addr_gen
  import oag_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int REG_IDX_W  = 4,
  parameter int BASE_SEL_W = 2,
  parameter int DISP_W     = 8,
  parameter int IMM_W      = 4
)(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic [3:0]            mode,
  input  logic [REG_IDX_W-1:0]  rxSel,
  input  logic [BASE_SEL_W-1:0] baseSel,
  input  logic [DISP_W-1:0]     dispField,
  input  logic [WORD_W-1:0]     postWord,
  input  logic [WORD_W-1:0]     instrCount,
  output logic [REG_IDX_W-1:0]  rdAddrA,
  input  logic [WORD_W-1:0]     rdDataA,
  output logic [REG_IDX_W-1:0]  rdAddrB,
  input  logic [WORD_W-1:0]     rdDataB,
  output logic                  memReq,
  output logic [WORD_W-1:0]     memAddr,
  input  logic                  memAck,
  input  logic [WORD_W-1:0]     memData,
  output logic                  valid,
  output logic                  isAddr,
  output logic [WORD_W-1:0]     result
);
  localparam int BASE_PFX_W = REG_IDX_W - BASE_SEL_W;

  strobeT strb;

  assign rdAddrA = rxSel;
  assign rdAddrB = {{BASE_PFX_W{1'b1}}, baseSel};

  oag_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode), .memAck(memAck),
    .strb(strb), .memReq(memReq), .valid(valid)
  );

  oag_datapath #(
    .WORD_W(WORD_W), .REG_IDX_W(REG_IDX_W), .DISP_W(DISP_W), .IMM_W(IMM_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .mode(mode), .rxSel(rxSel),
    .dispField(dispField), .postWord(postWord), .instrCount(instrCount),
    .rdDataA(rdDataA), .rdDataB(rdDataB), .memReq(memReq), .memAck(memAck),
    .memData(memData), .memAddr(memAddr), .result(result), .isAddr(isAddr)
  );
endmodule

// File: tb/opnd_addr_gen_tb.sv
`timescale 1ns/1ps
module opnd_addr_gen_tb;
  logic clk = 0, rstN = 0, start = 0, memAck = 0;
  logic [3:0] mode = 0, rxSel = 0;
  logic [1:0] baseSel = 0;
  logic [7:0] dispField = 0;
  logic [15:0] postWord = 0, instrCount = 0, memData = 0;
  logic [3:0] rdAddrA, rdAddrB;
  logic [15:0] rdDataA, rdDataB, memAddr, result;
  logic memReq, valid, isAddr;
  logic [15:0] regs [16];
  int nCmp = 0, nBad = 0;

  always #2.5 clk = ~clk;

  assign rdDataA = regs[rdAddrA];
  assign rdDataB = regs[rdAddrB];

  opnd_addr_gen u_dut (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode), .rxSel(rxSel),
    .baseSel(baseSel), .dispField(dispField), .postWord(postWord),
    .instrCount(instrCount), .rdAddrA(rdAddrA), .rdDataA(rdDataA),
    .rdAddrB(rdAddrB), .rdDataB(rdDataB), .memReq(memReq), .memAddr(memAddr),
    .memAck(memAck), .memData(memData), .valid(valid), .isAddr(isAddr),
    .result(result)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] idx(input logic [3:0] r);
    return (r != 0) ? regs[r] : 16'h0000;
  endfunction

  task automatic runOp(input logic [3:0] m, input logic [3:0] rx, input logic [1:0] bs,
                       input logic [7:0] d, input logic [15:0] pw, input logic [15:0] ic,
                       input logic [15:0] expVal, input logic expAddr, input string tag);
    @(negedge clk);
    mode = m; rxSel = rx; baseSel = bs; dispField = d; postWord = pw; instrCount = ic;
    start = 1;
    @(negedge clk);
    start = 0;
    chk({tag, " valid"}, {15'd0, valid}, 16'd1);
    chk({tag, " result"}, result, expVal);
    chk({tag, " isAddr"}, {15'd0, isAddr}, {15'd0, expAddr});
  endtask

  task automatic runInd(input logic [3:0] rx, input logic [15:0] pw, input int delay,
                        input logic [15:0] data, input logic poke);
    logic [15:0] ptr;
    ptr = pw + idx(rx);
    @(negedge clk);
    mode = 4'd2; rxSel = rx; postWord = pw; start = 1;
    @(negedge clk);
    start = 0;
    chk("R4 req raised", {15'd0, memReq}, 16'd1);
    chk("R4 no early valid", {15'd0, valid}, 16'd0);
    chk("R4 pointer", memAddr, ptr);
    for (int k = 0; k < delay; k++) begin
      if (poke && k == 0) begin mode = 4'd0; rxSel = 4'd3; start = 1; end
      @(negedge clk);
      start = 0; mode = 4'd2; rxSel = rx;
      chk("R4 req held", {15'd0, memReq}, 16'd1);
      chk("R4 pointer held", memAddr, ptr);
      chk("R11 no valid while pending", {15'd0, valid}, 16'd0);
    end
    memAck = 1; memData = data;
    @(negedge clk);
    memAck = 0; memData = 16'hDEAD;
    chk("R4 valid after ack", {15'd0, valid}, 16'd1);
    chk("R4 fetched result", result, data);
    chk("R4 isAddr", {15'd0, isAddr}, 16'd1);
    chk("R4 req dropped", {15'd0, memReq}, 16'd0);
    @(negedge clk);
    chk("R11 single valid", {15'd0, valid}, 16'd0);
  endtask

  initial begin
    #(5.0 * 150000);
    nBad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) regs[i] = 16'(i * 16'h1111 + 16'h0203);
    regs[15] = 16'hFFF8;
    regs[9]  = 16'hFF80;
    repeat (3) @(negedge clk);
    chk("R1 valid", {15'd0, valid}, 16'd0);
    chk("R1 memReq", {15'd0, memReq}, 16'd0);
    chk("R1 result", result, 16'd0);
    chk("R1 isAddr", {15'd0, isAddr}, 16'd0);
    rstN = 1;

    for (int r = 0; r < 16; r++) begin
      runOp(4'd0, 4'(r), 2'd0, 8'd0, 16'h0, 16'h0, regs[r], 1'b0, "R2 register");
      runOp(4'd1, 4'(r), 2'd0, 8'd0, 16'h1234, 16'h0, 16'h1234 + idx(4'(r)), 1'b1, "R3 direct");
      runOp(4'd1, 4'(r), 2'd0, 8'd0, 16'hFFF0, 16'h0, 16'hFFF0 + idx(4'(r)), 1'b1, "R3 direct wrap");
      runOp(4'd3, 4'(r), 2'd0, 8'd0, 16'h8001, 16'h0, 16'h8001 + idx(4'(r)), 1'b0, "R5 imm long");
      runOp(4'd4, 4'd0, 2'd0, {4'hA, 4'(r)}, 16'h0, 16'h0, 16'(r + 1), 1'b0, "R6 short pos");
      runOp(4'd5, 4'd0, 2'd0, {4'h5, 4'(r)}, 16'h0, 16'h0, 16'(0 - (r + 1)), 1'b0, "R7 short neg");
    end
    for (int d = 0; d < 256; d++) begin
      logic [15:0] se;
      se = {{8{d[7]}}, 8'(d)};
      runOp(4'd6, 4'd0, 2'd0, 8'(d), 16'h0, 16'h4000, 16'h4000 + se, 1'b1, "R8 counter rel");
    end
    runOp(4'd6, 4'd0, 2'd0, 8'h80, 16'h0, 16'h0010, 16'hFF90, 1'b1, "R8 counter rel wrap");
    for (int b = 0; b < 4; b++) begin
      for (int d = 0; d < 256; d += 51)
        runOp(4'd7, 4'd0, 2'(b), 8'(d), 16'h0, 16'h0, regs[12 + b] + 16'(d), 1'b1, "R9 base rel");
      for (int r = 0; r < 16; r++)
        runOp(4'd8, 4'(r), 2'(b), 8'd0, 16'h0, 16'h0, regs[12 + b] + idx(4'(r)), 1'b1, "R10 base idx");
    end
    for (int m = 9; m < 16; m++)
      runOp(4'(m), 4'd5, 2'd1, 8'h33, 16'h7777, 16'h1111, 16'h0000, 1'b0, "R12 undefined mode");

    for (int dl = 0; dl < 5; dl++)
      runInd(4'(dl * 3), 16'h2000 + 16'(dl), dl, 16'hA500 + 16'(dl), 1'b0);
    runInd(4'd15, 16'h0010, 3, 16'h5A5A, 1'b1);
    runInd(4'd0, 16'hFFFF, 2, 16'h0001, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule